// File: doc/BRIEF.md
# Four-Channel ISA DMA Cycle Engine

This block runs 8-bit, ISA-style bus cycles for four DMA channels and for a local CPU. Each channel holds a start address, a remaining byte count and a transfer direction, all loaded through a small configuration port. A device asks for service by raising its request line. The engine latches that request, picks the lowest-numbered channel that is waiting, and acknowledges it with an active-low line. It then runs one fly-by byte cycle: the device and the memory move the byte over the external data bus while the engine drives the address and the paired strobes.

Each DMA cycle has three phases. An address phase of one clock comes first. A strobe phase follows, lasting three clocks at minimum and stretched while the ready input is low. A release clock ends the cycle. AEN stays high for the whole cycle so that I/O slaves stay off the bus. After each byte the channel address steps up and the count steps down. Terminal count marks the byte that empties the channel.

CPU cycles share the same sequencer. A CPU cycle always has a fixed strobe length, ignores ready, keeps AEN low and drives or captures the data bus itself.

Top module: `isa_dma_engine`

## Requirements
- R1: During and right after reset, all acknowledges are high (inactive), all four strobes are high, aen_o is low, tc_o is low and cpu_done_o is low.
- R2: Priority is fixed. When several channels are waiting, the lowest channel index is served first. Each waiting channel gets one byte before any channel is served a second time.
- R3: A request seen high for a single clock while its channel has a nonzero count is remembered. That channel is served later even after drq_i has dropped.
- R4: At most one of dack_no is low at any time. The low line matches the channel served and stays unchanged from the address phase through the release clock.
- R5: For a DMA byte, cfg_dir_i = 0 (I/O to memory) pulls ior_no and memw_no low together. cfg_dir_i = 1 (memory to I/O) pulls memr_no and iow_no low together.
- R6: aen_o is high throughout every DMA cycle and low during every CPU cycle.
- R7: A DMA strobe lasts 3 clocks when ready_i is high. Each clock on which ready_i is sampled low after that minimum adds one clock.
- R8: A CPU cycle always strobes for exactly 3 clocks, whatever ready_i does. The encoding is cpu_io_i = 1 for I/O space or 0 for memory space, and cpu_wr_i = 1 for a write or 0 for a read. A write drives sd_o with sd_oe_o high. A read returns sd_i on cpu_rdata_o while cpu_done_o is high.
- R9: sa_o carries the channel's current address during a DMA cycle. After each byte the address rises by one, with carry across all 20 bits.
- R10: tc_o is high during the byte for which the count is 1. After that byte the count is 0, and further requests on that channel are ignored.
- R11: A configuration write loads a channel with a new address, count and direction. The next byte served on that channel uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the selected channel's registers |
| cfg_sel_i | input | 2 | Channel selected for loading |
| cfg_addr_i | input | 20 | Start address to load |
| cfg_cnt_i | input | 16 | Byte count to load |
| cfg_dir_i | input | 1 | Direction to load: 0 I/O to memory, 1 memory to I/O |
| drq_i | input | 4 | DMA requests, active high |
| dack_no | output | 4 | DMA acknowledges, active low |
| tc_o | output | 1 | Terminal count, high on a channel's last byte |
| ready_i | input | 1 | Wait request, low stretches a DMA strobe |
| cpu_req_i | input | 1 | CPU cycle request, held until cpu_done_o |
| cpu_io_i | input | 1 | CPU cycle space: 1 I/O, 0 memory |
| cpu_wr_i | input | 1 | CPU cycle kind: 1 write, 0 read |
| cpu_addr_i | input | 20 | CPU cycle address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data |
| cpu_done_o | output | 1 | CPU cycle finishing, one clock |
| sa_o | output | 20 | Bus address |
| sd_o | output | 8 | Bus data driven for CPU writes |
| sd_oe_o | output | 1 | Enable for sd_o |
| sd_i | input | 8 | Bus data read back |
| aen_o | output | 1 | Address enable, high during DMA cycles |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |

## Verification
The checker takes two things for granted. First, a channel is loaded only while no cycle is running on it. Second, cpu_req_i is held steady until cpu_done_o and then dropped within a clock. Without these, the acknowledge-hold and strobe-length properties could see a cycle restart in the middle of a byte. The stimulus loads channels only while the bus is idle. It pulses requests for exactly one clock and releases the CPU request on the clock where done is seen. It moves ready_i only during the strobe phase of a DMA cycle, or holds it low across a whole CPU cycle to show that ready_i is ignored there.

// File: rtl/isa_dma_pkg.sv
package isa_dma_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;
endpackage

// File: rtl/isa_dma_chan.sv
module isa_dma_chan #(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic          cfg_dir_i,
  input  logic          drq_i,
  input  logic          ack_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          elig_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q, pend_q;
  logic          live;

  assign live = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (cfg_we_i) begin
      addr_q <= cfg_addr_i;
      cnt_q  <= cfg_cnt_i;
      dir_q  <= cfg_dir_i;
      pend_q <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
      pend_q <= 1'b0;
    end else if (drq_i && !ack_i && live) begin
      pend_q <= 1'b1;  // latched: survives early withdrawal
    end
  end

  assign addr_o = addr_q;
  assign dir_o  = dir_q;
  assign elig_o = pend_q && live;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/isa_dma_arb.sv
module isa_dma_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/isa_dma_cyc.sv
module isa_dma_cyc
  import isa_dma_pkg::*;
#(
  parameter int STRB_MIN = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   dma_go_i,
  input  logic   cpu_go_i,
  input  logic   ready_i,
  output phase_e phase_o,
  output logic   dma_o,
  output logic   start_o,
  output logic   sample_o
);
  localparam int WW = $clog2(STRB_MIN);
  localparam logic [WW-1:0] W_LAST = WW'(STRB_MIN - 1);

  phase_e        ph_q;
  logic          dma_q;
  logic [WW-1:0] w_q;
  logic          exit_strb;

  assign start_o   = (ph_q == PH_IDLE) && (dma_go_i || cpu_go_i);
  // wait states only for engine-owned cycles
  assign exit_strb = (ph_q == PH_STRB) && (w_q == W_LAST) && (ready_i || !dma_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      dma_q <= 1'b0;
      w_q   <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_o) begin
          ph_q  <= PH_ADDR;
          dma_q <= dma_go_i;
        end
        PH_ADDR: begin
          ph_q <= PH_STRB;
          w_q  <= '0;
        end
        PH_STRB: begin
          if (exit_strb)        ph_q <= PH_FIN;
          else if (w_q != W_LAST) w_q <= w_q + 1'b1;
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = ph_q;
  assign dma_o    = dma_q;
  assign sample_o = exit_strb;
endmodule

// File: rtl/isa_dma_engine.sv
module isa_dma_engine
  import isa_dma_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int STRB_MIN = 3,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IW-1:0]   cfg_sel_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [CW-1:0]   cfg_cnt_i,
  input  logic            cfg_dir_i,
  input  logic [N_CH-1:0] drq_i,
  output logic [N_CH-1:0] dack_no,
  output logic            tc_o,
  input  logic            ready_i,
  input  logic            cpu_req_i,
  input  logic            cpu_io_i,
  input  logic            cpu_wr_i,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  output logic [DW-1:0]   cpu_rdata_o,
  output logic            cpu_done_o,
  output logic [AW-1:0]   sa_o,
  output logic [DW-1:0]   sd_o,
  output logic            sd_oe_o,
  input  logic [DW-1:0]   sd_i,
  output logic            aen_o,
  output logic            ior_no,
  output logic            iow_no,
  output logic            memr_no,
  output logic            memw_no
);
  logic [AW-1:0]   ch_addr [N_CH];
  logic [N_CH-1:0] ch_dir, ch_elig, ch_last, ch_ack, ch_step;
  logic            arb_any;
  logic [IW-1:0]   arb_idx, gnt_q;
  phase_e          phase;
  logic            is_dma, start, sample;
  logic            active, strb, fin, dir;
  logic            cpu_io_q, cpu_wr_q;
  logic [AW-1:0]   cpu_addr_q;
  logic [DW-1:0]   cpu_wd_q, cpu_rd_q;

  assign active = (phase != PH_IDLE);
  assign strb   = (phase == PH_STRB);
  assign fin    = (phase == PH_FIN);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_ack[c]  = active && is_dma && (gnt_q == IW'(c));
    assign ch_step[c] = fin && ch_ack[c];
    isa_dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_sel_i == IW'(c))),
      .cfg_addr_i (cfg_addr_i),
      .cfg_cnt_i  (cfg_cnt_i),
      .cfg_dir_i  (cfg_dir_i),
      .drq_i      (drq_i[c]),
      .ack_i      (ch_ack[c]),
      .step_i     (ch_step[c]),
      .addr_o     (ch_addr[c]),
      .dir_o      (ch_dir[c]),
      .elig_o     (ch_elig[c]),
      .last_o     (ch_last[c])
    );
  end

  isa_dma_arb #(.N(N_CH)) u_arb (
    .req_i (ch_elig),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  isa_dma_cyc #(.STRB_MIN(STRB_MIN)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dma_go_i (arb_any),
    .cpu_go_i (cpu_req_i),
    .ready_i  (ready_i),
    .phase_o  (phase),
    .dma_o    (is_dma),
    .start_o  (start),
    .sample_o (sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q      <= '0;
      cpu_io_q   <= 1'b0;
      cpu_wr_q   <= 1'b0;
      cpu_addr_q <= '0;
      cpu_wd_q   <= '0;
      cpu_rd_q   <= '0;
    end else begin
      if (start && arb_any) gnt_q <= arb_idx;
      if (start && !arb_any) begin
        cpu_io_q   <= cpu_io_i;
        cpu_wr_q   <= cpu_wr_i;
        cpu_addr_q <= cpu_addr_i;
        cpu_wd_q   <= cpu_wdata_i;
      end
      if (sample && !is_dma) cpu_rd_q <= sd_i;
    end
  end

  assign dir     = ch_dir[gnt_q];
  assign dack_no = ~ch_ack;
  assign aen_o   = active && is_dma;
  assign tc_o    = active && is_dma && ch_last[gnt_q];
  assign sa_o    = !active ? '0 : (is_dma ? ch_addr[gnt_q] : cpu_addr_q);

  assign ior_no  = ~(strb && (is_dma ? !dir :  cpu_io_q && !cpu_wr_q));
  assign memw_no = ~(strb && (is_dma ? !dir : !cpu_io_q &&  cpu_wr_q));
  assign memr_no = ~(strb && (is_dma ?  dir : !cpu_io_q && !cpu_wr_q));
  assign iow_no  = ~(strb && (is_dma ?  dir :  cpu_io_q &&  cpu_wr_q));

  assign sd_oe_o     = active && !is_dma && cpu_wr_q;
  assign sd_o        = cpu_wd_q;
  assign cpu_rdata_o = cpu_rd_q;
  assign cpu_done_o  = fin && !is_dma;
endmodule

// File: rtl/isa_dma_sva.sv
module isa_dma_sva #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] dack_no,
  input logic            aen_o,
  input logic            tc_o,
  input logic            ior_no,
  input logic            iow_no,
  input logic            memr_no,
  input logic            memw_no
);
  logic any_strb;
  assign any_strb = !ior_no || !iow_no || !memr_no || !memw_no;

  assert_ack_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));

  assert_ack_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1 && $past(dack_no) != '1) |-> $stable(dack_no));

  assert_no_read_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ior_no && !memr_no) && !(!iow_no && !memw_no));

  assert_aen_with_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) |-> aen_o);

  assert_aen_only_dma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> (dack_no != '1));

  assert_min_memw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(memw_no) |-> (!$past(memw_no, 2) && !$past(memw_no, 3)));

  assert_min_memr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(memr_no) |-> (!$past(memr_no, 2) && !$past(memr_no, 3)));

  assert_cpu_no_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strb && !aen_o) |-> (dack_no == '1));

  assert_tc_in_dma_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> aen_o);
endmodule

bind isa_dma_engine isa_dma_sva #(.N_CH(N_CH)) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dack_no (dack_no),
  .aen_o   (aen_o),
  .tc_o    (tc_o),
  .ior_no  (ior_no),
  .iow_no  (iow_no),
  .memr_no (memr_no),
  .memw_no (memw_no)
);

// File: tb/tb_isa_dma_engine.sv
`timescale 1ns/1ps
module tb_isa_dma_engine;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [19:0] cfg_addr = 0;
  logic [15:0] cfg_cnt = 0;
  logic        cfg_dir = 0;
  logic [3:0]  drq = 0;
  logic [3:0]  dack_no;
  logic        tc_o, ready = 1;
  logic        cpu_req = 0, cpu_io = 0, cpu_wr = 0;
  logic [19:0] cpu_addr = 0;
  logic [7:0]  cpu_wd = 0, cpu_rdata_o, sd_o, sd_in = 0;
  logic        cpu_done_o, sd_oe_o, aen_o, ior_no, iow_no, memr_no, memw_no;
  logic [19:0] sa_o;

  int errs = 0, checks = 0, wd = 0;
  int run = 0, last_len = 0, ncyc = 0;
  logic [19:0] st_addr;
  logic [3:0]  st_dack, st_str;
  logic        st_aen, st_tc, st_oe;
  logic [7:0]  st_sd;
  logic [3:0]  glog [64];

  always #2.5 clk = ~clk;

  isa_dma_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr),
    .cfg_cnt_i(cfg_cnt), .cfg_dir_i(cfg_dir),
    .drq_i(drq), .dack_no(dack_no), .tc_o(tc_o), .ready_i(ready),
    .cpu_req_i(cpu_req), .cpu_io_i(cpu_io), .cpu_wr_i(cpu_wr),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wd), .cpu_rdata_o(cpu_rdata_o),
    .cpu_done_o(cpu_done_o), .sa_o(sa_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
    .sd_i(sd_in), .aen_o(aen_o), .ior_no(ior_no), .iow_no(iow_no),
    .memr_no(memr_no), .memw_no(memw_no)
  );

  // strobe monitor: snapshot at strobe start, length at strobe end
  always @(negedge clk) if (rst_n) begin
    if (!ior_no || !iow_no || !memr_no || !memw_no) begin
      if (run == 0) begin
        st_addr = sa_o; st_dack = dack_no; st_aen = aen_o; st_tc = tc_o;
        st_str = {ior_no, iow_no, memr_no, memw_no};
        st_oe = sd_oe_o; st_sd = sd_o;
        glog[ncyc % 64] = dack_no;
      end
      run++;
    end else if (run != 0) begin
      last_len = run; run = 0; ncyc++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog R4 cycle completion: act=hung exp=done");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input int ch, input logic [19:0] a, input logic [15:0] n, input bit d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(ch); cfg_addr = a; cfg_cnt = n; cfg_dir = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); drq = m;
    @(negedge clk); drq = '0;
  endtask

  task automatic wait_cyc(input int target);
    while (ncyc < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cpu_op(input bit io, input bit wr, input logic [19:0] a,
                        input logic [7:0] d, input logic [3:0] exp_str);
    int n0;
    logic [7:0] rd;
    n0 = ncyc;
    @(negedge clk);
    ready = 0; sd_in = ~d;
    cpu_io = io; cpu_wr = wr; cpu_addr = a; cpu_wd = d; cpu_req = 1;
    @(negedge clk);
    while (!cpu_done_o) @(negedge clk);
    rd = cpu_rdata_o;
    cpu_req = 0;
    wait_cyc(n0 + 1);
    ready = 1;
    chk(last_len == 3, "R8 cpu strobe length", last_len, 3);
    chk(st_aen == 0, "R6 aen low on cpu cycle", st_aen, 0);
    chk(st_dack == 4'hF, "R8 no ack on cpu cycle", st_dack, 4'hF);
    chk(st_str == exp_str, "R8 cpu strobe select", st_str, exp_str);
    chk(st_addr == a, "R8 cpu address", st_addr, a);
    if (wr) chk(st_oe && st_sd == d, "R8 cpu write data", {st_oe, st_sd}, {1'b1, d});
    else    chk(rd == ~d, "R8 cpu read data", rd, ~d);
  endtask

  initial begin
    logic [19:0] base;
    int n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dack_no == 4'hF, "R1 ack idle", dack_no, 4'hF);
    chk({ior_no, iow_no, memr_no, memw_no} == 4'hF, "R1 strobes idle",
        {ior_no, iow_no, memr_no, memw_no}, 4'hF);
    chk({aen_o, tc_o, cpu_done_o} == 3'b000, "R1 aen/tc/done low",
        {aen_o, tc_o, cpu_done_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // sweep: every channel, both directions, three bytes each
    for (int d = 0; d < 2; d++) begin
      for (int ch = 0; ch < 4; ch++) begin
        bit dir;
        dir = 1'(d) ^ 1'(ch);
        base = {2'b00, 2'(ch), 16'hFFFE};
        prog(ch, base, 16'd3, dir);
        for (int j = 0; j < 3; j++) begin
          n0 = ncyc;
          pulse(4'(1 << ch));  // R3 one-clock request
          wait_cyc(n0 + 1);
          chk(ncyc == n0 + 1, "R3 short request served", ncyc, n0 + 1);
          chk(st_addr == base + 20'(j), "R9 address step", st_addr, base + 20'(j));
          chk(st_dack == ~4'(1 << ch), "R4 ack line", st_dack, ~4'(1 << ch));
          chk(st_aen == 1, "R6 aen high on dma", st_aen, 1);
          chk(st_str == (dir ? 4'b1001 : 4'b0110), "R5 strobe pair", st_str,
              dir ? 4'b1001 : 4'b0110);
          chk(st_tc == (j == 2), "R10 terminal count", st_tc, (j == 2));
          chk(last_len == 3, "R7 default strobe", last_len, 3);
        end
        n0 = ncyc;
        pulse(4'(1 << ch));
        repeat (20) @(negedge clk);
        chk(ncyc == n0 && dack_no == 4'hF, "R10 exhausted channel ignores request",
            ncyc, n0);
      end
    end

    // R2 fixed priority
    for (int ch = 0; ch < 4; ch++) prog(ch, 20'h100 * 20'(ch), 16'd8, 1'b0);
    n0 = ncyc;
    pulse(4'b1111);
    wait_cyc(n0 + 4);
    for (int k = 0; k < 4; k++)
      chk(glog[(n0 + k) % 64] == ~4'(1 << k), "R2 order all four",
          glog[(n0 + k) % 64], ~4'(1 << k));
    n0 = ncyc;
    pulse(4'b1010);
    wait_cyc(n0 + 2);
    chk(glog[n0 % 64] == 4'b1101, "R2 ch1 before ch3", glog[n0 % 64], 4'b1101);
    chk(glog[(n0 + 1) % 64] == 4'b0111, "R2 ch3 second", glog[(n0 + 1) % 64], 4'b0111);

    // R7 wait states on ch0
    for (int k = 0; k < 5; k++) begin
      n0 = ncyc;
      pulse(4'b0001);
      while (memw_no) @(negedge clk);
      repeat (2) @(negedge clk);
      if (k > 0) begin
        ready = 0;
        repeat (k) @(negedge clk);
        ready = 1;
      end
      wait_cyc(n0 + 1);
      chk(last_len == 3 + k, "R7 stretched strobe", last_len, 3 + k);
    end

    // R8 cpu cycles, ready held low
    cpu_op(1, 1, 20'hABCDE, 8'h3C, 4'b1011);
    cpu_op(1, 0, 20'h00123, 8'h5A, 4'b0111);
    cpu_op(0, 1, 20'hFFFFF, 8'hC3, 4'b1110);
    cpu_op(0, 0, 20'h80000, 8'h96, 4'b1101);

    // R11 reprogram exhausted channel
    prog(1, 20'h4_2000, 16'd1, 1'b1);
    n0 = ncyc;
    pulse(4'b0010);
    wait_cyc(n0 + 1);
    chk(st_addr == 20'h4_2000, "R11 new address", st_addr, 20'h4_2000);
    chk(st_str == 4'b1001, "R11 new direction", st_str, 4'b1001);
    chk(st_tc == 1, "R11 new count gives tc", st_tc, 1);

    summary();
    $finish;
  end
endmodule